// File: doc/BRIEF.md
# Exception Entry Frame Sequencer

This block performs the hardware side of entering an exception or interrupt handler on a simple 32-bit processor model. A request carries the vector number, the event kind (fault, trap or external interrupt), the current and next instruction addresses, the flags word, the code and stack segment selectors, the stack pointer and the current privilege level. The block reads the 64-bit gate descriptor for the vector from the descriptor table and returns the handler's code selector and entry offset. It then writes the return frame onto the stack, one 32-bit word per cycle.

The descriptor table register is 48 bits wide. Bits 47:16 hold the table base and bits 15:0 hold the table limit. The descriptor address is the base plus eight times the vector. Privilege level 0 is the kernel level. An event taken at any other level first moves to a kernel stack, whose selector and pointer come from task-state inputs. In that case the old stack selector and pointer are saved ahead of the usual frame. Handler dispatch, instruction fetch and the return path belong to the surrounding core.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held, busy, done, protErr, memRdEn and stkWrEn are all low.
- R2: One cycle after a request is accepted, memRdEn is high and memRdAddr equals tableReg[47:16] + 8*reqVector, provided the descriptor lies within the limit. The descriptor data is expected on memRdData one cycle after the read strobe.
- R3: If 8*reqVector + 7 exceeds tableReg[15:0], protErr pulses for one cycle, two cycles after acceptance. No descriptor read and no stack write take place, and done is not raised.
- R4: handlerCs equals descriptor bits 31:16. handlerEip equals descriptor bits 63:48 followed by bits 15:0.
- R5: For a fault (reqKind 2'b00), the saved return address is curEip.
- R6: For a trap (reqKind 2'b01) or an external interrupt (reqKind 2'b10 or 2'b11), the saved return address is nextEip.
- R7: When curCpl is 0, three words are pushed below curEsp, in this order: EFLAGS, then CS zero-extended, then the return address. newSs equals curSs.
- R8: When curCpl is not 0, the stack is first set to taskSs:taskEsp. Five words are then pushed in this order: old SS zero-extended, old ESP, EFLAGS, CS, return address. newSs equals taskSs.
- R9: Pushes occur on consecutive cycles starting three cycles after acceptance. Each push address is 4 below the previous stack pointer: the first is 4 below the starting pointer, and each later one is 4 below the one before.
- R10: busy is high from the cycle after acceptance until the last push. A request presented while busy is ignored.
- R11: done pulses for one cycle, the cycle after the last push. At that point newEsp equals the address of the last pushed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Event request strobe |
| reqVector | input | 8 | Vector number |
| reqKind | input | 2 | 00 fault, 01 trap, 10/11 external interrupt |
| curEip | input | 32 | Address of the current instruction |
| nextEip | input | 32 | Address of the following instruction |
| reqEflags | input | 32 | Flags word to save |
| curCs | input | 16 | Current code selector |
| curSs | input | 16 | Current stack selector |
| curEsp | input | 32 | Current stack pointer |
| curCpl | input | 2 | Current privilege level |
| tableReg | input | 48 | Descriptor table base (47:16) and limit (15:0) |
| taskSs | input | 16 | Kernel stack selector from the task state |
| taskEsp | input | 32 | Kernel stack pointer from the task state |
| memRdEn | output | 1 | Descriptor read strobe |
| memRdAddr | output | 32 | Descriptor byte address |
| memRdData | input | 64 | Descriptor data, one cycle after the strobe |
| stkWrEn | output | 1 | Stack write strobe |
| stkWrAddr | output | 32 | Stack write address |
| stkWrData | output | 32 | Stack write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Entry complete pulse |
| protErr | output | 1 | Descriptor outside the table limit |
| handlerCs | output | 16 | Handler code selector |
| handlerEip | output | 32 | Handler entry offset |
| newSs | output | 16 | Stack selector in effect for the handler |
| newEsp | output | 32 | Stack pointer after the frame |

## Verification
With acceptance at clock edge 0, the descriptor read is visible after edge 0 and protErr after edge 1. The first push appears after edge 2, and done appears after edge 2+N, where N is 3 or 5. The bench drives inputs and samples every output on the falling edge. It checks the read strobe and address on the first falling edge after acceptance. It then records each stack write on the falling edges that follow until done or protErr appears. Finally it compares the recorded order and the flags against values computed from the vector, kind and privilege level.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    KIND_FAULT  = 2'b00,
    KIND_TRAP   = 2'b01,
    KIND_EXT    = 2'b10,
    KIND_EXT_B  = 2'b11
  } evKind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_PUSH
  } seqState_t;

  localparam int SLOT_W = 3;
  localparam logic [SLOT_W-1:0] SLOT_OLD_SS  = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_OLD_ESP = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_FLAGS   = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_CS      = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_RET     = 3'd4;

  typedef struct packed {
    logic              capture;
    logic              readGate;
    logic              loadGate;
    logic              pushEn;
    logic [SLOT_W-1:0] slot;
  } dpCtrl_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    limitOk,
  input  logic    switchStack,
  output dpCtrl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    protErr
);
  seqState_t         state, stateNext;
  logic [SLOT_W-1:0] slotR;
  logic              doneR, errR;

  always_comb begin
    ctl       = '0;
    ctl.slot  = slotR;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.capture = 1'b1;
        stateNext   = ST_CHECK;
      end
      ST_CHECK: begin
        ctl.readGate = limitOk;
        stateNext    = limitOk ? ST_READ : ST_IDLE;
      end
      ST_READ: begin
        ctl.loadGate = 1'b1;
        stateNext    = ST_PUSH;
      end
      ST_PUSH: begin
        ctl.pushEn = 1'b1;
        if (slotR == SLOT_RET) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      slotR <= SLOT_FLAGS;
      doneR <= 1'b0;
      errR  <= 1'b0;
    end else begin
      state <= stateNext;
      doneR <= (state == ST_PUSH) && (slotR == SLOT_RET);
      errR  <= (state == ST_CHECK) && !limitOk;
      if (state == ST_READ)
        slotR <= switchStack ? SLOT_OLD_SS : SLOT_FLAGS;
      else if (state == ST_PUSH)
        slotR <= slotR + 1'b1;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = doneR;
  assign protErr = errR;
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SEL_W  = 16,
  parameter int VEC_W  = 8,
  parameter int CPL_W  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctl,
  input  logic [VEC_W-1:0]    reqVector,
  input  logic [1:0]          reqKind,
  input  logic [WORD_W-1:0]   curEip,
  input  logic [WORD_W-1:0]   nextEip,
  input  logic [WORD_W-1:0]   reqEflags,
  input  logic [SEL_W-1:0]    curCs,
  input  logic [SEL_W-1:0]    curSs,
  input  logic [WORD_W-1:0]   curEsp,
  input  logic [CPL_W-1:0]    curCpl,
  input  logic [WORD_W+SEL_W-1:0] tableReg,
  input  logic [SEL_W-1:0]    taskSs,
  input  logic [WORD_W-1:0]   taskEsp,
  input  logic [2*WORD_W-1:0] memRdData,
  output logic                limitOk,
  output logic                switchStack,
  output logic [WORD_W-1:0]   memRdAddr,
  output logic [WORD_W-1:0]   stkWrAddr,
  output logic [WORD_W-1:0]   stkWrData,
  output logic [SEL_W-1:0]    handlerCs,
  output logic [WORD_W-1:0]   handlerEip,
  output logic [SEL_W-1:0]    newSs,
  output logic [WORD_W-1:0]   newEsp
);
  localparam int GATE_W     = 2 * WORD_W;
  localparam int GATE_SH    = $clog2(GATE_W / 8);
  localparam int IDX_W      = VEC_W + GATE_SH;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int SEL_PAD    = WORD_W - SEL_W;

  logic [VEC_W-1:0]  vecR;
  logic [WORD_W-1:0] retR, flagsR, espR, baseR, tEspR, spR;
  logic [SEL_W-1:0]  csR, ssR, limitR, tSsR, gateCsR, newSsR;
  logic [CPL_W-1:0]  cplR;
  logic [WORD_W-1:0] gateOffR;
  logic [SEL_W-1:0]  lastByte;
  logic              unusedGateBits;

  assign unusedGateBits = ^memRdData[GATE_W-SEL_W-1:2*SEL_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecR <= '0; retR <= '0; flagsR <= '0; espR <= '0; baseR <= '0;
      tEspR <= '0; csR <= '0; ssR <= '0; limitR <= '0; tSsR <= '0; cplR <= '0;
      gateCsR <= '0; gateOffR <= '0; spR <= '0; newSsR <= '0;
    end else begin
      if (ctl.capture) begin
        vecR   <= reqVector;
        retR   <= (evKind_t'(reqKind) == KIND_FAULT) ? curEip : nextEip;
        flagsR <= reqEflags;
        csR    <= curCs;
        ssR    <= curSs;
        espR   <= curEsp;
        cplR   <= curCpl;
        baseR  <= tableReg[WORD_W+SEL_W-1:SEL_W];
        limitR <= tableReg[SEL_W-1:0];
        tSsR   <= taskSs;
        tEspR  <= taskEsp;
      end
      if (ctl.loadGate) begin
        gateCsR  <= memRdData[2*SEL_W-1:SEL_W];
        gateOffR <= {memRdData[GATE_W-1 -: SEL_W], memRdData[SEL_W-1:0]};
        spR      <= switchStack ? tEspR : espR;
        newSsR   <= switchStack ? tSsR : ssR;
      end else if (ctl.pushEn) begin
        spR <= spR - WORD_W'(WORD_BYTES);
      end
    end
  end

  assign switchStack = (cplR != '0);
  assign lastByte    = {{(SEL_W-IDX_W){1'b0}}, vecR, {GATE_SH{1'b1}}};
  assign limitOk     = (lastByte <= limitR);
  assign memRdAddr   = baseR + {{(WORD_W-IDX_W){1'b0}}, vecR, {GATE_SH{1'b0}}};
  assign stkWrAddr   = spR - WORD_W'(WORD_BYTES);

  always_comb begin
    unique case (ctl.slot)
      SLOT_OLD_SS:  stkWrData = {{SEL_PAD{1'b0}}, ssR};
      SLOT_OLD_ESP: stkWrData = espR;
      SLOT_FLAGS:   stkWrData = flagsR;
      SLOT_CS:      stkWrData = {{SEL_PAD{1'b0}}, csR};
      default:      stkWrData = retR;
    endcase
  end

  assign handlerCs  = gateCsR;
  assign handlerEip = gateOffR;
  assign newSs      = newSsR;
  assign newEsp     = spR;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SEL_W  = 16,
  parameter int VEC_W  = 8,
  parameter int CPL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [VEC_W-1:0]        reqVector,
  input  logic [1:0]              reqKind,
  input  logic [WORD_W-1:0]       curEip,
  input  logic [WORD_W-1:0]       nextEip,
  input  logic [WORD_W-1:0]       reqEflags,
  input  logic [SEL_W-1:0]        curCs,
  input  logic [SEL_W-1:0]        curSs,
  input  logic [WORD_W-1:0]       curEsp,
  input  logic [CPL_W-1:0]        curCpl,
  input  logic [WORD_W+SEL_W-1:0] tableReg,
  input  logic [SEL_W-1:0]        taskSs,
  input  logic [WORD_W-1:0]       taskEsp,
  output logic                    memRdEn,
  output logic [WORD_W-1:0]       memRdAddr,
  input  logic [2*WORD_W-1:0]     memRdData,
  output logic                    stkWrEn,
  output logic [WORD_W-1:0]       stkWrAddr,
  output logic [WORD_W-1:0]       stkWrData,
  output logic                    busy,
  output logic                    done,
  output logic                    protErr,
  output logic [SEL_W-1:0]        handlerCs,
  output logic [WORD_W-1:0]       handlerEip,
  output logic [SEL_W-1:0]        newSs,
  output logic [WORD_W-1:0]       newEsp
);
  dpCtrl_t ctl;
  logic    limitOk, switchStack;

  exc_entry_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .limitOk(limitOk),
    .switchStack(switchStack), .ctl(ctl), .busy(busy), .done(done), .protErr(protErr)
  );

  exc_entry_dp #(.WORD_W(WORD_W), .SEL_W(SEL_W), .VEC_W(VEC_W), .CPL_W(CPL_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqVector(reqVector), .reqKind(reqKind),
    .curEip(curEip), .nextEip(nextEip), .reqEflags(reqEflags), .curCs(curCs),
    .curSs(curSs), .curEsp(curEsp), .curCpl(curCpl), .tableReg(tableReg),
    .taskSs(taskSs), .taskEsp(taskEsp), .memRdData(memRdData),
    .limitOk(limitOk), .switchStack(switchStack), .memRdAddr(memRdAddr),
    .stkWrAddr(stkWrAddr), .stkWrData(stkWrData), .handlerCs(handlerCs),
    .handlerEip(handlerEip), .newSs(newSs), .newEsp(newEsp)
  );

  assign memRdEn = ctl.readGate;
  assign stkWrEn = ctl.pushEn;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRdEn,
  input logic              stkWrEn,
  input logic [WORD_W-1:0] stkWrAddr,
  input logic              busy,
  input logic              done,
  input logic              protErr
);
  localparam int WORD_BYTES = WORD_W / 8;

  AST_READ_THEN_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> busy && !stkWrEn);  // R2
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    protErr |-> !stkWrEn && !$past(memRdEn));  // R3
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stkWrEn && $past(stkWrEn) |-> stkWrAddr == $past(stkWrAddr) - WORD_W'(WORD_BYTES));  // R9
  AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    stkWrEn |-> busy);  // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R11
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !protErr);  // R11
endmodule

bind exc_entry_seq exc_entry_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rstN(rstN), .memRdEn(memRdEn), .stkWrEn(stkWrEn),
  .stkWrAddr(stkWrAddr), .busy(busy), .done(done), .protErr(protErr)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqVector = '0;
  logic [1:0]  reqKind = '0;
  logic [31:0] curEip = '0, nextEip = '0, reqEflags, curEsp, taskEsp;
  logic [15:0] curCs, curSs, taskSs;
  logic [1:0]  curCpl = '0;
  logic [47:0] tableReg = '0;
  logic        memRdEn, stkWrEn, busy, done, protErr;
  logic [31:0] memRdAddr, stkWrAddr, stkWrData, handlerEip, newEsp;
  logic [63:0] memRdData = '0;
  logic [15:0] handlerCs, newSs;

  localparam logic [31:0] BASE = 32'h0004_0000;
  localparam logic [31:0] CESP = 32'h0000_8000;
  localparam logic [31:0] TESP = 32'h0002_0000;
  localparam logic [31:0] EFL  = 32'h0000_0246;
  localparam logic [15:0] CCS  = 16'h001B;
  localparam logic [15:0] CSS  = 16'h0023;
  localparam logic [15:0] TSS  = 16'h0010;

  // {vector, kind, cpl, limit, expErr, expPushes}
  localparam logic [31:0] VEC_TBL [7] = '{
    {8'd14,  2'd0, 2'd0, 16'h07FF, 1'b0, 3'd3},
    {8'd3,   2'd1, 2'd3, 16'h07FF, 1'b0, 3'd5},
    {8'd32,  2'd2, 2'd0, 16'h07FF, 1'b0, 3'd3},
    {8'd255, 2'd3, 2'd1, 16'h07FF, 1'b0, 3'd5},
    {8'd32,  2'd0, 2'd0, 16'h0106, 1'b1, 3'd0},
    {8'd0,   2'd1, 2'd3, 16'h0007, 1'b0, 3'd5},
    {8'd1,   2'd0, 2'd2, 16'h0007, 1'b1, 3'd0}
  };

  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector), .reqKind(reqKind),
    .curEip(curEip), .nextEip(nextEip), .reqEflags(reqEflags), .curCs(curCs), .curSs(curSs),
    .curEsp(curEsp), .curCpl(curCpl), .tableReg(tableReg), .taskSs(taskSs), .taskEsp(taskEsp),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData), .stkWrEn(stkWrEn),
    .stkWrAddr(stkWrAddr), .stkWrData(stkWrData), .busy(busy), .done(done), .protErr(protErr),
    .handlerCs(handlerCs), .handlerEip(handlerEip), .newSs(newSs), .newEsp(newEsp)
  );

  function automatic logic [63:0] gateFor(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5A5, 16'h8E00, a[15:0] + 16'h0008, a[15:0] ^ 16'h1234};
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= gateFor(memRdAddr);

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runEvent(input logic [7:0] v, input logic [1:0] k, input logic [1:0] cpl,
                          input logic [15:0] lim, input bit expErr, input int expN, input bit poke);
    logic [31:0] wa [8];
    logic [31:0] wd [8];
    logic [31:0] ew [5];
    logic [31:0] ret, sp0, gAddr;
    logic [63:0] g;
    logic [15:0] hcs, nss;
    logic [31:0] heip, nesp;
    int nW = 0;
    bit gotDone = 0, gotErr = 0, sw;
    reqVector = v; reqKind = k; curCpl = cpl; tableReg = {BASE, lim};
    curEip = 32'h0010_2000 + {20'h0, v, 4'h0}; nextEip = curEip + 32'd3;
    @(negedge clk) reqValid = 1'b1;
    @(negedge clk) reqValid = 1'b0;
    check("R10", "busy after accept", busy, 1);
    check(expErr ? "R3" : "R2", "read strobe", memRdEn, !expErr);
    gAddr = BASE + {21'h0, v, 3'b000};
    if (!expErr) check("R2", "read address", memRdAddr, gAddr);
    for (int c = 0; c < 20 && !gotDone && !gotErr; c++) begin
      @(negedge clk);
      if (stkWrEn && nW < 8) begin wa[nW] = stkWrAddr; wd[nW] = stkWrData; nW++; end
      gotDone = done; gotErr = protErr;
      hcs = handlerCs; heip = handlerEip; nss = newSs; nesp = newEsp;
      if (poke && c == 1) begin reqValid = 1'b1; reqVector = v ^ 8'h5A; curCpl = 2'd0; end
      if (poke && c == 2) reqValid = 1'b0;
    end
    reqValid = 1'b0;
    check("R3", "error flag", gotErr, expErr);
    check(expErr ? "R3" : "R11", "done flag", gotDone, !expErr);
    check(cpl != 0 ? "R8" : "R7", "push count", nW, expN);
    if (!expErr) begin
      g   = gateFor(gAddr);
      ret = (k == 2'b00) ? curEip : nextEip;
      sw  = (cpl != 0);
      sp0 = sw ? TESP : CESP;
      if (sw) begin
        ew[0] = {16'h0, CSS}; ew[1] = CESP; ew[2] = EFL; ew[3] = {16'h0, CCS}; ew[4] = ret;
      end else begin
        ew[0] = EFL; ew[1] = {16'h0, CCS}; ew[2] = ret; ew[3] = '0; ew[4] = '0;
      end
      for (int i = 0; i < expN && i < nW; i++) begin
        check("R9", "push address", wa[i], sp0 - 32'(4 * (i + 1)));
        if (i == expN - 1) check(k == 2'b00 ? "R5" : "R6", "return address", wd[i], ew[i]);
        else check(sw ? "R8" : "R7", "frame word", wd[i], ew[i]);
      end
      check("R4", "handler selector", hcs, g[31:16]);
      check("R4", "handler offset", heip, {g[63:48], g[15:0]});
      check("R11", "final stack pointer", nesp, sp0 - 32'(4 * expN));
      check(sw ? "R8" : "R7", "handler stack selector", nss, sw ? TSS : CSS);
    end
    @(negedge clk);
    check("R11", "done single pulse", done, 0);
    check("R10", "idle after sequence", busy, 0);
    check("R3", "error single pulse", protErr, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    reqEflags = EFL; curCs = CCS; curSs = CSS; curEsp = CESP; taskSs = TSS; taskEsp = TESP;
    repeat (3) @(negedge clk);
    reqValid = 1'b1;
    @(negedge clk);
    check("R1", "reset outputs", {busy, done, protErr, memRdEn, stkWrEn}, 5'b0);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", busy, 0);

    foreach (VEC_TBL[i]) begin
      runEvent(VEC_TBL[i][31:24], VEC_TBL[i][23:22], VEC_TBL[i][21:20],
               VEC_TBL[i][19:4], VEC_TBL[i][3], int'(VEC_TBL[i][2:0]), 1'b0);
    end

    // R10: request during busy is ignored; frame matches the first request
    runEvent(8'd50, 2'b00, 2'd3, 16'h07FF, 1'b0, 5, 1'b1);
    repeat (3) @(negedge clk);
    check("R10", "poked request not started", busy, 0);

    // R1: reset in the middle of a frame
    reqVector = 8'd40; reqKind = 2'b01; curCpl = 2'd3; tableReg = {BASE, 16'h07FF};
    @(negedge clk) reqValid = 1'b1;
    @(negedge clk) reqValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "mid-frame reset", {busy, done, protErr, memRdEn, stkWrEn}, 5'b0);
    rstN = 1'b1;
    @(negedge clk);
    runEvent(8'd33, 2'b10, 2'd0, 16'h07FF, 1'b0, 3, 1'b0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule